// File: doc/BRIEF.md
# Mixed-Phase Serial Register Master

This block runs one register access on a serial sensor bus per request. A user asserts `start` for one cycle with a 9-bit register address, a direction flag and a 16-bit write word. The block then drives a single 26-bit serial frame while chip select is held low. The frame carries the address first, then the direction bit, then sixteen data bits. When the frame is over and chip select has gone high again, the block returns the captured data with a one-cycle `done` pulse.

The two serial lines use different edge conventions within the same frame. Outgoing bits are changed while the serial clock is low, so the slave takes them on the rising edge. Incoming bits are launched by the slave on the rising edge and taken by this master on the falling edge. The frame is exactly 26 clock pulses long, with no padding to a byte size.

Clock rate, setup time and hold time are fixed by parameters, and each is counted in system clock cycles.

Top module: `mixphase_spi_master`

## Requirements
- R1: A frame shifts out 26 bits, most significant bit first: the 9-bit address, then the direction bit, then 16 data bits.
- R2: `csN` is low for the whole frame. Every `sclk` edge falls inside the low window, and `csN` is low whenever `busy` is high apart from the final hold and release cycles.
- R3: `mosi` changes only while `sclk` is low, and it is stable at every `sclk` rising edge.
- R4: `miso` is sampled on the falling edges of `sclk`. After the frame, `rdata` holds the 16 bits sampled on the last 16 falling edges, the first sampled bit being the most significant.
- R5: Each frame has exactly 26 rising and 26 falling `sclk` edges, and `sclk` is low between frames.
- R6: The direction bit is 1 for a read and 0 for a write. On a read, `mosi` is low for all 16 data bits.
- R7: Each high phase and each low phase of `sclk` lasts `HALF_DIV` system clock cycles.
- R8: The first `sclk` rise comes `SETUP_HALVES*HALF_DIV` cycles after `csN` falls. `csN` rises `HOLD_HALVES*HALF_DIV` cycles after the last `sclk` fall.
- R9: `start` is ignored while `busy` is high. It starts no frame, and the running frame does not change.
- R10: `done` is high for exactly one cycle, one cycle after `csN` rises. In that cycle `busy` is low and `rdata` is valid.
- R11: After reset, `sclk` is low, `csN` is high, `mosi` is low, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an access |
| addr | input | 9 | Register address |
| rdNotWr | input | 1 | 1 = read, 0 = write |
| wdata | input | 16 | Write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Data captured from `miso` |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The bench builds the block with `HALF_DIV=2`, `SETUP_HALVES=2` and `HOLD_HALVES=3`. Because setup and hold use different counts, a swap of the two delays or an off-by-one half period shows up as a timing mismatch. The small divider keeps each frame to about a hundred cycles, which leaves room for many accesses. These include back-to-back accesses and a start pulse issued in the middle of a frame. A divider of two also separates the cycle in which `mosi` changes from the next rising edge, so a launch on the wrong edge is visible.

// File: rtl/mps_pkg.sv
package mps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_DONE
  } mps_state_t;

  // strobes issued by the control toward the datapath
  typedef struct packed {
    logic load;      // latch a new frame
    logic shiftOut;  // advance the outgoing bit (falling edge)
    logic capture;   // take one incoming bit (falling edge)
  } mps_strobe_t;

endpackage

// File: rtl/mps_ctrl.sv
module mps_ctrl
  import mps_pkg::*;
#(
  parameter int FRAME_W      = 26,
  parameter int HALF_DIV     = 4,
  parameter int SETUP_HALVES = 1,
  parameter int HOLD_HALVES  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        sclk,
  output logic        csN,
  output logic        busy,
  output logic        done,
  output mps_strobe_t strobe
);

  localparam int DIV_W  = $clog2(HALF_DIV) + 1;
  localparam int PH_MAX = (SETUP_HALVES > HOLD_HALVES) ? SETUP_HALVES : HOLD_HALVES;
  localparam int PH_W   = $clog2(PH_MAX) + 1;
  localparam int BIT_W  = $clog2(FRAME_W) + 1;

  mps_state_t       stateQ;
  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             sclkQ, csNQ, doneQ;
  logic             tick;

  assign tick = (divCnt == DIV_W'(HALF_DIV - 1));

  always_comb begin
    strobe          = '0;
    strobe.load     = start && (stateQ == ST_IDLE);
    strobe.shiftOut = (stateQ == ST_SHIFT) && tick && sclkQ;
    strobe.capture  = (stateQ == ST_SHIFT) && tick && sclkQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      divCnt   <= '0;
      phaseCnt <= '0;
      bitCnt   <= '0;
      sclkQ    <= 1'b0;
      csNQ     <= 1'b1;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (stateQ == ST_SETUP || stateQ == ST_SHIFT || stateQ == ST_HOLD)
        divCnt <= tick ? '0 : divCnt + 1'b1;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            csNQ     <= 1'b0;
            divCnt   <= '0;
            phaseCnt <= '0;
            stateQ   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            if (phaseCnt == PH_W'(SETUP_HALVES - 1)) begin
              sclkQ  <= 1'b1;
              bitCnt <= '0;
              stateQ <= ST_SHIFT;
            end else begin
              phaseCnt <= phaseCnt + 1'b1;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (sclkQ) begin
              sclkQ <= 1'b0;
              if (bitCnt == BIT_W'(FRAME_W - 1)) begin
                phaseCnt <= '0;
                stateQ   <= ST_HOLD;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end else begin
              sclkQ <= 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            if (phaseCnt == PH_W'(HOLD_HALVES - 1)) begin
              csNQ   <= 1'b1;
              stateQ <= ST_DONE;
            end else begin
              phaseCnt <= phaseCnt + 1'b1;
            end
          end
        end
        ST_DONE: begin
          doneQ  <= 1'b1;
          stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign sclk = sclkQ;
  assign csN  = csNQ;
  assign done = doneQ;
  assign busy = (stateQ != ST_IDLE);

  // R5: bit index never runs past the frame
  p_bit_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < BIT_W'(FRAME_W));

  // R10: completion lasts a single cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a start seen while busy never reloads the frame
  p_no_reload_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |-> !strobe.load);

endmodule

// File: rtl/mps_datapath.sv
module mps_datapath
  import mps_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mps_strobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdNotWr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rdata
);

  localparam int FRAME_W = ADDR_W + 1 + DATA_W;

  logic [FRAME_W-1:0] frameQ;
  logic [DATA_W-1:0]  capQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '0;
    end else if (strobe.load) begin
      frameQ <= {addr, rdNotWr, rdNotWr ? {DATA_W{1'b0}} : wdata};
    end else if (strobe.shiftOut) begin
      frameQ <= {frameQ[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capQ <= '0;
    end else if (strobe.capture) begin
      capQ <= {capQ[DATA_W-2:0], miso};
    end
  end

  assign mosi  = frameQ[FRAME_W-1];
  assign rdata = capQ;

  // R1: a load and a shift never collide
  p_load_shift_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.shiftOut));

endmodule

// File: rtl/mixphase_spi_master.sv
module mixphase_spi_master
  import mps_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 16,
  parameter int HALF_DIV     = 4,
  parameter int SETUP_HALVES = 1,
  parameter int HOLD_HALVES  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdNotWr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);

  localparam int FRAME_W = ADDR_W + 1 + DATA_W;

  generate
    if (HALF_DIV < 1 || SETUP_HALVES < 1 || HOLD_HALVES < 1 || DATA_W < 2) begin : g_badParam
      $error("mixphase_spi_master: timing parameters must be at least 1");
    end
  endgenerate

  mps_strobe_t strobe;

  mps_ctrl #(
    .FRAME_W     (FRAME_W),
    .HALF_DIV    (HALF_DIV),
    .SETUP_HALVES(SETUP_HALVES),
    .HOLD_HALVES (HOLD_HALVES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .sclk  (sclk),
    .csN   (csN),
    .busy  (busy),
    .done  (done),
    .strobe(strobe)
  );

  mps_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .addr   (addr),
    .rdNotWr(rdNotWr),
    .wdata  (wdata),
    .miso   (miso),
    .mosi   (mosi),
    .rdata  (rdata)
  );

  // R2: clock pulses only inside the chip-select window
  p_sclk_in_cs_r2: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  // R2: chip select low implies an access in progress
  p_cs_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  // R3: outgoing data holds while the clock is high
  p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi));

  // R10: completion only after release, with the block idle
  p_done_released_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !busy));

  // R11: outgoing line idles low between frames
  p_mosi_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !busy) |-> !mosi);

endmodule

// File: tb/sim_mixphase_spi_master.sv
module sim_mixphase_spi_master;

  localparam int AW = 9;
  localparam int DW = 16;
  localparam int FW = AW + 1 + DW;
  localparam int HD = 2;
  localparam int SU = 2;
  localparam int HO = 3;
  localparam time TCK = 20ns;

  typedef struct packed {
    logic [FW-1:0] frame;
    logic [DW-1:0] rd;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic rdNotWr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic busy, done, sclk, csN, mosi;
  logic miso = 1'b0;
  logic [DW-1:0] rdata;

  int testsRun = 0;
  int testsFailed = 0;
  item_t expQ[$];
  int pushed = 0;
  int framesSeen = 0;

  logic [DW-1:0] slaveData = '0;
  logic [FW-1:0] rxFrame = '0;
  int riseCnt = 0, fallCnt = 0;
  time tCsFall, tPrevRise, tLastFall, tCsRise;
  bit setupBad, periodBad, holdBad, mosiBad, csBad;

  always #(TCK/2) clk = ~clk;

  mixphase_spi_master #(
    .ADDR_W(AW), .DATA_W(DW), .HALF_DIV(HD),
    .SETUP_HALVES(SU), .HOLD_HALVES(HO)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .addr(addr), .rdNotWr(rdNotWr),
    .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .sclk(sclk),
    .csN(csN), .mosi(mosi), .miso(miso)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model: samples mosi on rise, launches miso on rise
  always @(negedge csN) begin
    framesSeen++;
    rxFrame = '0; riseCnt = 0; fallCnt = 0;
    setupBad = 0; periodBad = 0; holdBad = 0; mosiBad = 0; csBad = 0;
    tCsFall = $time;
  end

  always @(posedge sclk) begin
    rxFrame = {rxFrame[FW-2:0], mosi};
    riseCnt++;
    if (csN) csBad = 1;
    if (riseCnt == 1) begin
      if ($time - tCsFall != SU * HD * TCK) setupBad = 1;
    end else if ($time - tPrevRise != 2 * HD * TCK) periodBad = 1;
    if ($time - tLastFall != HD * TCK && riseCnt > 1) periodBad = 1;
    tPrevRise = $time;
    if (riseCnt > FW - DW) miso = slaveData[DW - 1 - (riseCnt - (FW - DW + 1))];
    else miso = 1'b0;
  end

  always @(negedge sclk) begin
    fallCnt++;
    if (csN) csBad = 1;
    if ($time - tPrevRise != HD * TCK) periodBad = 1;
    tLastFall = $time;
  end

  always @(posedge csN) begin
    tCsRise = $time;
    if (tCsRise - tLastFall != HO * HD * TCK) holdBad = 1;
  end

  always @(mosi) begin
    if (sclk) mosiBad = 1;
  end

  // monitor: pops expectation at each completion
  initial begin
    forever begin
      @(negedge clk);
      if (done && rstN) begin
        item_t e;
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected completion", 1, 0);
        end else begin
          e = expQ.pop_front();
          check(rxFrame == e.frame, "R1/R6 frame bits", 32'(rxFrame), 32'(e.frame));
          check(rdata == e.rd, "R4 read data", 32'(rdata), 32'(e.rd));
          check(riseCnt == FW && fallCnt == FW, "R5 edge count", 32'(riseCnt*256 + fallCnt), 32'(FW*256 + FW));
          check(!csBad, "R2 edges inside cs", 32'(csBad), 0);
          check(!mosiBad, "R3 mosi change while sclk high", 32'(mosiBad), 0);
          check(!periodBad, "R7 half period", 32'(periodBad), 0);
          check(!setupBad && !holdBad, "R8 setup/hold", 32'({setupBad, holdBad}), 0);
          check(!busy && csN && !sclk, "R10 idle at done", 32'({busy, csN, sclk}), 32'(3'b010));
          check($time - tCsRise == TCK + TCK/2, "R10 done one cycle after release", 32'(($time - tCsRise)/1ns), 32'((TCK + TCK/2)/1ns));
          @(negedge clk);
          check(!done, "R10 done single cycle", 32'(done), 0);
        end
      end
    end
  end

  // driver: pushes expectation and pulses start
  task automatic doAccess(input logic [AW-1:0] a, input logic rw, input logic [DW-1:0] wd, input logic [DW-1:0] sd);
    item_t e;
    while (busy) @(negedge clk);
    e.frame = {a, rw, rw ? {DW{1'b0}} : wd};
    e.rd = sd;
    expQ.push_back(e);
    pushed++;
    slaveData = sd;
    addr = a; rdNotWr = rw; wdata = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!sclk && csN && !mosi && !busy && !done, "R11 reset state",
          32'({sclk, csN, mosi, busy, done}), 32'(5'b01000));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!sclk && csN && !mosi && !busy, "R11 idle after reset",
          32'({sclk, csN, mosi, busy}), 32'(4'b0100));

    doAccess(9'h1A5, 1'b0, 16'hBEEF, 16'h0000);   // write, R1
    waitIdle();
    doAccess(9'h0FF, 1'b1, 16'hFFFF, 16'h1234);   // read, mosi low in data, R6
    waitIdle();
    doAccess(9'h1FF, 1'b1, 16'h0000, 16'hFFFF);   // all ones read, R4
    waitIdle();
    doAccess(9'h000, 1'b0, 16'h8001, 16'hA5C3);   // edge bits write
    // back-to-back: start issued as soon as busy drops
    doAccess(9'h100, 1'b1, 16'h5555, 16'h8001);
    waitIdle();
    check(!sclk && !mosi && csN, "R5 sclk/mosi idle between frames", 32'({sclk, mosi, csN}), 32'(3'b001));

    // R9: start pulse and new inputs during a frame are ignored
    doAccess(9'h0A3, 1'b0, 16'h3C3C, 16'h0F0F);
    repeat (30) @(negedge clk);
    addr = 9'h155; rdNotWr = 1'b1; wdata = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    addr = 9'h1FF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitIdle();
    repeat (30) @(negedge clk);
    check(framesSeen == pushed, "R9 no extra frame from ignored start", 32'(framesSeen), 32'(pushed));
    check(expQ.size() == 0, "R10 every access completed", 32'(expQ.size()), 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule